// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address by fetching page-table descriptors from memory. A client offers an address on a valid/ready request port. The walker then reads one or two 32-bit descriptors through a simple read port, which has an address handshake followed by a data-valid response. It returns either the translated physical address or a fault on a valid/ready result port. There is no descriptor cache and no TLB, so every request walks the tables.

The first-level table has one 32-bit entry for every 1 MiB of virtual space. Its base is a 16 KiB aligned input. A first-level entry can be a fault, a 1 MiB section, or a link to a 256-entry second-level table. A second-level entry can be a fault, a 4 KiB small page, or a 64 KiB large page. A large page is written into 16 neighbouring second-level slots, each with the same base. The walker handles one request at a time.

Top module: `iova_table_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `mem_req_valid` and `res_valid` are both 0.
- R2: The first read of a walk goes to `{table_base[31:14], va[31:20], 2'b00}`. The low 14 bits of `table_base` are ignored.
- R3: A first-level entry whose bits [1:0] are `10` ends the walk after one read, with `res_fault`=0 and `res_addr = {desc[31:20], va[19:0]}`.
- R4: A first-level entry whose bits [1:0] are `00` or `11` ends the walk after one read, with `res_fault`=1 and `res_addr` equal to the request address.
- R5: A first-level entry whose bits [1:0] are `01` starts a second read at `{desc[31:10], va[19:12], 2'b00}`.
- R6: A second-level entry whose bits [1:0] are `00` gives `res_fault`=1 and `res_addr` equal to the request address.
- R7: A second-level entry whose bits [1:0] are `01` is a large page, giving `res_addr = {desc[31:16], va[15:0]}`. Any of the 16 slots that share that entry therefore yields the same page base.
- R8: A second-level entry whose bit 1 is set (`10` or `11`) is a small page, giving `res_addr = {desc[31:12], va[11:0]}`.
- R9: `req_ready` stays 0 from the moment a request is accepted until its result has been taken. While `res_valid` is high and `res_ready` is low, the result stays valid and unchanged.
- R10: No walk issues more than two reads. While `mem_req_valid` is high and `mem_req_ready` is low, the read stays valid and its address unchanged.
- R11: `table_base` is sampled when the request is accepted. Later changes to it do not affect the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| table_base | input | 32 | First-level table base; bits [13:0] are ignored |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | Walker is idle and accepts a request |
| req_va | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read address |
| mem_req_addr | output | 32 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data is present |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result is present |
| res_ready | input | 1 | Client takes the result |
| res_fault | output | 1 | Result is a translation fault |
| res_addr | output | 32 | Physical address, or the faulting virtual address |

## Verification
The walks are driven from a vector table covering each descriptor outcome: section, both first-level fault codes, small pages of both codes, large pages reached through two different slots, and a second-level fault. The expected descriptor addresses separate an index taken from the wrong address field from a correct one. The offsets in the results show whether the mask matches the page size. Some vectors stall the read and result handshakes, which shows whether the outputs hold steady. Some change `table_base` and keep `req_valid` asserted during the walk, which shows whether the base is sampled on acceptance and whether a second request slips in. One vector puts non-zero low bits in the base to show that they are dropped.

// File: rtl/iova_walk_pkg.sv
package iova_walk_pkg;

   // Walk sequencer states
   typedef enum logic [2:0] {
      WS_IDLE,
      WS_L1_REQ,
      WS_L1_WAIT,
      WS_L2_REQ,
      WS_L2_WAIT,
      WS_DONE
   } walk_state_e;

   // Outcome of a first-level entry
   typedef enum logic [1:0] {
      L1K_FAULT,
      L1K_LINK,
      L1K_SECTION
   } l1_kind_e;

   // Outcome of a second-level entry
   typedef enum logic [1:0] {
      L2K_FAULT,
      L2K_LARGE,
      L2K_SMALL
   } l2_kind_e;

endpackage

// File: rtl/iova_l1_decode.sv
module iova_l1_decode
   import iova_walk_pkg::*;
(
   input  logic [1:0] type_bits,
   output l1_kind_e   kind
);

   // 01 links to a second-level table, 10 maps a section, 00/11 fault
   always_comb begin
      unique case (type_bits)
         2'b01:   kind = L1K_LINK;
         2'b10:   kind = L1K_SECTION;
         default: kind = L1K_FAULT;
      endcase
   end

endmodule

// File: rtl/iova_l2_decode.sv
module iova_l2_decode
   import iova_walk_pkg::*;
(
   input  logic [1:0] type_bits,
   output l2_kind_e   kind
);

   // bit 1 set marks a small page; 01 a large page; 00 a fault
   always_comb begin
      if (type_bits[1])
         kind = L2K_SMALL;
      else if (type_bits[0])
         kind = L2K_LARGE;
      else
         kind = L2K_FAULT;
   end

endmodule

// File: rtl/iova_addr_form.sv
module iova_addr_form #(
   parameter int ADDR_W      = 32,
   parameter int SECT_SHIFT  = 20,
   parameter int LPAGE_SHIFT = 16,
   parameter int SPAGE_SHIFT = 12,
   parameter int BASE_ALIGN  = 14,
   parameter int DESC_LOG2   = 2
) (
   input  logic [ADDR_W-1:BASE_ALIGN]                            base_hi,
   input  logic [ADDR_W-1:0]                                     va,
   input  logic [ADDR_W-1:SECT_SHIFT-SPAGE_SHIFT+DESC_LOG2]      desc_hi,
   output logic [ADDR_W-1:0]                                     l1_addr,
   output logic [ADDR_W-1:0]                                     l2_addr,
   output logic [ADDR_W-1:0]                                     pa_sect,
   output logic [ADDR_W-1:0]                                     pa_large,
   output logic [ADDR_W-1:0]                                     pa_small
);

   localparam int L2_LSB = SECT_SHIFT - SPAGE_SHIFT + DESC_LOG2;

   // descriptor slot = table base + index * entry size
   assign l1_addr  = {base_hi, va[ADDR_W-1:SECT_SHIFT], {DESC_LOG2{1'b0}}};
   assign l2_addr  = {desc_hi, va[SECT_SHIFT-1:SPAGE_SHIFT], {DESC_LOG2{1'b0}}};

   // page base masked to the page size, offset from the virtual address
   assign pa_sect  = {desc_hi[ADDR_W-1:SECT_SHIFT],  va[SECT_SHIFT-1:0]};
   assign pa_large = {desc_hi[ADDR_W-1:LPAGE_SHIFT], va[LPAGE_SHIFT-1:0]};
   assign pa_small = {desc_hi[ADDR_W-1:SPAGE_SHIFT], va[SPAGE_SHIFT-1:0]};

   logic unused_lsb;
   assign unused_lsb = ^desc_hi[SPAGE_SHIFT-1:L2_LSB];

endmodule

// File: rtl/iova_table_walker.sv
module iova_table_walker
   import iova_walk_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int SECT_SHIFT  = 20,
   parameter int LPAGE_SHIFT = 16,
   parameter int SPAGE_SHIFT = 12,
   parameter int BASE_ALIGN  = 14,
   parameter int DESC_LOG2   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] table_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_va,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [ADDR_W-1:0] mem_rsp_data,
   output logic              res_valid,
   input  logic              res_ready,
   output logic              res_fault,
   output logic [ADDR_W-1:0] res_addr
);

   localparam int L1_IDX_W = ADDR_W - SECT_SHIFT;
   localparam int L2_IDX_W = SECT_SHIFT - SPAGE_SHIFT;
   localparam int L2_LSB   = L2_IDX_W + DESC_LOG2;

   // elaboration-time parameter checks
   if (!(SPAGE_SHIFT < LPAGE_SHIFT && LPAGE_SHIFT < SECT_SHIFT && SECT_SHIFT < ADDR_W)) begin : g_bad_sizes
      $error("page size shifts must increase strictly and stay below ADDR_W");
   end
   if (BASE_ALIGN != L1_IDX_W + DESC_LOG2) begin : g_bad_align
      $error("BASE_ALIGN must equal the first-level table size in address bits");
   end
   if (L2_LSB > SPAGE_SHIFT) begin : g_bad_l2
      $error("second-level table base must not lie above the small page base");
   end

   walk_state_e              state;
   logic [ADDR_W-1:0]        va_q;
   logic [ADDR_W-1:BASE_ALIGN] base_q;
   logic [ADDR_W-1:0]        l2_addr_q;
   logic                     fault_q;
   logic [ADDR_W-1:0]        addr_q;

   l1_kind_e                 l1_kind;
   l2_kind_e                 l2_kind;
   logic [ADDR_W-1:0]        l1_addr, l2_addr, pa_sect, pa_large, pa_small;

   iova_l1_decode u_l1_dec (
      .type_bits (mem_rsp_data[1:0]),
      .kind      (l1_kind)
   );

   iova_l2_decode u_l2_dec (
      .type_bits (mem_rsp_data[1:0]),
      .kind      (l2_kind)
   );

   iova_addr_form #(
      .ADDR_W      (ADDR_W),
      .SECT_SHIFT  (SECT_SHIFT),
      .LPAGE_SHIFT (LPAGE_SHIFT),
      .SPAGE_SHIFT (SPAGE_SHIFT),
      .BASE_ALIGN  (BASE_ALIGN),
      .DESC_LOG2   (DESC_LOG2)
   ) u_form (
      .base_hi  (base_q),
      .va       (va_q),
      .desc_hi  (mem_rsp_data[ADDR_W-1:L2_LSB]),
      .l1_addr  (l1_addr),
      .l2_addr  (l2_addr),
      .pa_sect  (pa_sect),
      .pa_large (pa_large),
      .pa_small (pa_small)
   );

   logic unused_bits;
   assign unused_bits = ^{mem_rsp_data[L2_LSB-1:2], table_base[BASE_ALIGN-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= WS_IDLE;
         va_q      <= '0;
         base_q    <= '0;
         l2_addr_q <= '0;
         fault_q   <= 1'b0;
         addr_q    <= '0;
      end else begin
         unique case (state)
            WS_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_va;
                  base_q <= table_base[ADDR_W-1:BASE_ALIGN];
                  state  <= WS_L1_REQ;
               end
            end
            WS_L1_REQ: begin
               if (mem_req_ready) state <= WS_L1_WAIT;
            end
            WS_L1_WAIT: begin
               if (mem_rsp_valid) begin
                  unique case (l1_kind)
                     L1K_SECTION: begin
                        fault_q <= 1'b0;
                        addr_q  <= pa_sect;
                        state   <= WS_DONE;
                     end
                     L1K_LINK: begin
                        l2_addr_q <= l2_addr;
                        state     <= WS_L2_REQ;
                     end
                     default: begin
                        fault_q <= 1'b1;
                        addr_q  <= va_q;
                        state   <= WS_DONE;
                     end
                  endcase
               end
            end
            WS_L2_REQ: begin
               if (mem_req_ready) state <= WS_L2_WAIT;
            end
            WS_L2_WAIT: begin
               if (mem_rsp_valid) begin
                  unique case (l2_kind)
                     L2K_SMALL: begin
                        fault_q <= 1'b0;
                        addr_q  <= pa_small;
                     end
                     L2K_LARGE: begin
                        fault_q <= 1'b0;
                        addr_q  <= pa_large;
                     end
                     default: begin
                        fault_q <= 1'b1;
                        addr_q  <= va_q;
                     end
                  endcase
                  state <= WS_DONE;
               end
            end
            WS_DONE: begin
               if (res_ready) state <= WS_IDLE;
            end
            default: state <= WS_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == WS_IDLE);
   assign mem_req_valid = (state == WS_L1_REQ) || (state == WS_L2_REQ);
   assign mem_req_addr  = (state == WS_L2_REQ) ? l2_addr_q : l1_addr;
   assign res_valid     = (state == WS_DONE);
   assign res_fault     = fault_q;
   assign res_addr      = addr_q;

endmodule

// File: rtl/iova_table_walker_chk.sv
module iova_table_walker_chk #(
   parameter int ADDR_W     = 32,
   parameter int SECT_SHIFT = 20,
   parameter int BASE_ALIGN = 14,
   parameter int DESC_LOG2  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] table_base,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_va,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              res_valid,
   input logic              res_ready,
   input logic              res_fault,
   input logic [ADDR_W-1:0] res_addr
);

   logic [ADDR_W-1:0] va_seen;
   logic [ADDR_W-1:BASE_ALIGN] base_seen;
   logic [1:0] reads;

   logic unused_base;
   assign unused_base = ^table_base[BASE_ALIGN-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         va_seen   <= '0;
         base_seen <= '0;
         reads     <= '0;
      end else if (req_valid && req_ready) begin
         va_seen   <= req_va;
         base_seen <= table_base[ADDR_W-1:BASE_ALIGN];
         reads     <= '0;
      end else if (mem_req_valid && mem_req_ready && reads != 2'd3) begin
         reads     <= reads + 2'd1;
      end
   end

   // R1 / R9: idle and busy are exclusive
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req_valid && !res_valid));

   // R9: result held while back-pressured
   p_hold_res_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) && $stable(res_fault)));

   // R10: read request held while back-pressured
   p_hold_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R10: at most two reads per walk
   p_two_reads_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (reads < 2'd2));

   // R2 / R11: first read address from the sampled base and the request
   p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && reads == 2'd0) |->
         (mem_req_addr == {base_seen, va_seen[ADDR_W-1:SECT_SHIFT], {DESC_LOG2{1'b0}}}));

   // R4 / R6: a fault returns the request address
   p_fault_va_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fault) |-> (res_addr == va_seen));

   // R3: a one-read translation keeps the section offset
   p_sect_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_fault && reads == 2'd1) |->
         (res_addr[SECT_SHIFT-1:0] == va_seen[SECT_SHIFT-1:0]));

endmodule

bind iova_table_walker iova_table_walker_chk #(
   .ADDR_W     (ADDR_W),
   .SECT_SHIFT (SECT_SHIFT),
   .BASE_ALIGN (BASE_ALIGN),
   .DESC_LOG2  (DESC_LOG2)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .table_base    (table_base),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_va        (req_va),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .res_valid     (res_valid),
   .res_ready     (res_ready),
   .res_fault     (res_fault),
   .res_addr      (res_addr)
);

// File: tb/iova_table_walker_test.sv
`timescale 1ns/1ps
module iova_table_walker_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] table_base = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        res_valid;
   logic        res_ready = 1'b0;
   logic        res_fault;
   logic [31:0] res_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   iova_table_walker uut (
      .clk(clk), .rst_n(rst_n), .table_base(table_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .res_valid(res_valid),
      .res_ready(res_ready), .res_fault(res_fault), .res_addr(res_addr)
   );

   typedef struct packed {
      logic [7:0]  rq;
      logic [31:0] va;
      logic [31:0] base;
      logic [31:0] d1;
      logic [31:0] d2;
      logic [31:0] a1;
      logic [31:0] a2;
      logic        efault;
      logic [31:0] eaddr;
      logic [1:0]  ereads;
      logic        stall;
      logic        noise;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      // R3 section
      '{8'd3, 32'h1234_5678, 32'h8000_4000, 32'hABC0_0002, 32'h0, 32'h8000_448C, 32'h0, 1'b0, 32'hABC4_5678, 2'd1, 1'b0, 1'b0},
      // R4 first-level code 00
      '{8'd4, 32'hFFF0_0010, 32'h0001_C000, 32'h1234_5670, 32'h0, 32'h0001_FFFC, 32'h0, 1'b1, 32'hFFF0_0010, 2'd1, 1'b1, 1'b0},
      // R4 first-level code 11
      '{8'd4, 32'h0000_0ABC, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0, 32'h0000_0000, 32'h0, 1'b1, 32'h0000_0ABC, 2'd1, 1'b0, 1'b0},
      // R8 small page code 10, R5 second address
      '{8'd8, 32'h2034_5ABC, 32'h4000_8000, 32'h1111_2C01, 32'h5555_6002, 32'h4000_880C, 32'h1111_2D14, 1'b0, 32'h5555_6ABC, 2'd2, 1'b1, 1'b0},
      // R8 small page code 11, R9 request held high while busy
      '{8'd8, 32'h0010_F123, 32'h0000_4000, 32'h0000_0401, 32'h9876_5FFF, 32'h0000_4004, 32'h0000_043C, 1'b0, 32'h9876_5123, 2'd2, 1'b0, 1'b1},
      // R7 large page, junk in link low bits
      '{8'd7, 32'h7FFA_BCDE, 32'hC000_0000, 32'h2000_03FD, 32'h3333_4FF1, 32'hC000_1FFC, 32'h2000_02AC, 1'b0, 32'h3333_BCDE, 2'd2, 1'b1, 1'b0},
      // R7 same large page through another slot
      '{8'd7, 32'h7FFA_5432, 32'hC000_0000, 32'h2000_03FD, 32'h3333_4FF1, 32'hC000_1FFC, 32'h2000_0294, 1'b0, 32'h3333_5432, 2'd2, 1'b0, 1'b0},
      // R6 second-level fault
      '{8'd6, 32'h0055_5555, 32'h0000_C000, 32'h0ABC_D801, 32'hFFFF_FFFC, 32'h0000_C014, 32'h0ABC_D954, 1'b1, 32'h0055_5555, 2'd2, 1'b0, 1'b0},
      // R3 section at top of space
      '{8'd3, 32'hFFFF_FFFF, 32'hFFFF_C000, 32'h0010_0002, 32'h0, 32'hFFFF_FFFC, 32'h0, 1'b0, 32'h001F_FFFF, 2'd1, 1'b0, 1'b1},
      // R2 low base bits ignored
      '{8'd2, 32'h0030_0000, 32'h0000_7ABC, 32'hFFF0_0002, 32'h0, 32'h0000_400C, 32'h0, 1'b0, 32'hFFF0_0000, 2'd1, 1'b0, 1'b0}
   };

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      logic [31:0] addrs [2];
      int nreads = 0;
      bit got = 1'b0;
      bit busy_ok = 1'b1;
      logic        r_fault = 1'b0;
      logic [31:0] r_addr = '0;
      addrs[0] = '0;
      addrs[1] = '0;
      @(negedge clk);
      check(req_ready == 1'b1, $sformatf("R9 idle before vec %0d", idx), {31'd0, req_ready}, 32'd1);
      req_valid  = 1'b1;
      req_va     = v.va;
      table_base = v.base;
      @(negedge clk);
      // R11: scramble the base after acceptance
      table_base = ~v.base;
      if (v.noise) req_va = ~v.va;
      else req_valid = 1'b0;
      for (int cyc = 0; cyc < 40 && !got; cyc++) begin
         if (req_ready) busy_ok = 1'b0;
         if (mem_req_valid) begin
            if (nreads < 2) addrs[nreads] = mem_req_addr;
            if (v.stall) begin
               @(negedge clk);
               check(mem_req_valid && mem_req_addr == addrs[nreads > 1 ? 1 : nreads],
                     "R10 read held under stall", mem_req_addr, addrs[nreads > 1 ? 1 : nreads]);
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            if (v.stall) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = (nreads == 0) ? v.d1 : v.d2;
            nreads++;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = 32'hDEAD_BEEF;
         end else if (res_valid) begin
            r_fault = res_fault;
            r_addr  = res_addr;
            if (v.stall) begin
               @(negedge clk);
               check(res_valid && res_addr == r_addr && res_fault == r_fault,
                     "R9 result held under stall", res_addr, r_addr);
            end
            res_ready = 1'b1;
            req_valid = 1'b0;
            @(negedge clk);
            res_ready = 1'b0;
            got = 1'b1;
         end else begin
            @(negedge clk);
         end
      end
      req_valid = 1'b0;
      check(got, $sformatf("R%0d result present, vec %0d", v.rq, idx), {31'd0, got}, 32'd1);
      check(busy_ok, $sformatf("R9 busy during vec %0d", idx), {31'd0, busy_ok}, 32'd1);
      check(addrs[0] == v.a1, $sformatf("R2/R11 first read addr, vec %0d", idx), addrs[0], v.a1);
      if (v.ereads == 2'd2)
         check(addrs[1] == v.a2, $sformatf("R5 second read addr, vec %0d", idx), addrs[1], v.a2);
      check(nreads == int'(v.ereads), $sformatf("R10 read count, vec %0d", idx), nreads, {30'd0, v.ereads});
      check(r_fault == v.efault, $sformatf("R%0d fault flag, vec %0d", v.rq, idx), {31'd0, r_fault}, {31'd0, v.efault});
      check(r_addr == v.eaddr, $sformatf("R%0d result addr, vec %0d", v.rq, idx), r_addr, v.eaddr);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready == 1'b1, "R1 req_ready after reset", {31'd0, req_ready}, 32'd1);
      check(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", {31'd0, mem_req_valid}, 32'd0);
      check(res_valid == 1'b0, "R1 res_valid after reset", {31'd0, res_valid}, 32'd0);
      for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
      // R9: idle again with nothing pending
      @(negedge clk);
      check(req_ready && !mem_req_valid && !res_valid, "R9 idle after last walk", {31'd0, req_ready}, 32'd1);
      // R1: reset in the middle of a walk returns to idle
      req_valid = 1'b1; req_va = 32'h0100_0000; table_base = 32'h0;
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !mem_req_valid, "R1 reset aborts walk", {31'd0, mem_req_valid}, 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      finished = 1'b1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule